// File: doc/BRIEF.md
# Word-Dirty Write-Back Cache Controller

This block is a direct-mapped data cache controller placed between a CPU load/store port and a single-word memory port. It keeps tags, valid flags and dirty flags only, with no data payload. This is enough to decide hits and misses and to drive the memory traffic a real cache would produce. Each word address is cut into word offset, line index and tag with fixed bit slices. Each line carries one dirty flag per word.

A parameter chooses how write hits are handled. In write-back mode the write hit only marks the word dirty. In write-through mode the write hit also writes that word to memory. A write miss bypasses the cache and goes to memory, and it never allocates a line. A read miss first walks the victim line and writes back only its dirty words. It then refills all words of the new line in ascending order. While memory work is pending, the controller holds the CPU busy. Saturating counters record read hits, read misses, write hits, write misses and busy (stall) cycles.

Top module: `wbc_cache_ctl`

## Requirements
- R1: A word address splits as offset = bits [OFF_W-1:0], index = the next IDX_W bits, tag = the remaining upper bits (OFF_W = log2 of words per line, IDX_W = log2 of line count). Two addresses hit the same line only when both index and tag match, and lines at different indices are independent.
- R2: Access type codes are 0 = instruction fetch and 1 = data load, both handled as reads, and 2 = data store. Code 3 is ignored: no counter changes, no busy cycle and no memory access.
- R3: A read hit increments the read-hit counter, raises no busy cycle and makes no memory access. Counters change only in the cycle a request is accepted.
- R4: A read miss increments the read-miss counter, performs the victim write-back phase and then reads words 0 to WORDS_PER_LINE-1 of the new line in order. It then leaves the line valid with the new tag and all dirty flags clear. Each memory request holds its address and direction until its done pulse.
- R5: In write-through mode (WRITE_BACK=0), a write hit increments the write-hit counter and writes that word to memory.
- R6: In write-back mode (WRITE_BACK=1), a write hit increments the write-hit counter and sets the word's dirty flag, with no memory access and no busy cycle.
- R7: During replacement, only the victim words whose dirty flags are set are written to memory, in ascending word order, at the victim's tag and index. A clean word costs one scan cycle.
- R8: A write miss increments the write-miss counter and writes the word straight to memory. Tags, valid and dirty flags are unchanged, so a cached line stays a hit and the written address still misses on a later read.
- R9: cpu_busy is high on exactly the cycles spent on memory work, and the stall counter increments once per such cycle. Each memory word takes the memory's latency plus one cycle (the done cycle).
- R10: All counters saturate at their all-ones value instead of wrapping.
- R11: After reset, all lines are invalid, all counters are zero, and cpu_busy and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request strobe, taken when cpu_busy is low |
| cpu_type | input | 2 | Access type: 0 fetch, 1 load, 2 store, 3 ignored |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_busy | output | 1 | High while the controller waits on memory |
| mem_req | output | 1 | Memory word request, held until mem_done |
| mem_we | output | 1 | Direction of the memory request (1 = write) |
| mem_addr | output | ADDR_W | Word address of the memory request |
| mem_done | input | 1 | Single-cycle completion pulse from memory |
| rd_hit_cnt | output | CNT_W | Saturating read-hit count |
| rd_miss_cnt | output | CNT_W | Saturating read-miss count |
| wr_hit_cnt | output | CNT_W | Saturating write-hit count |
| wr_miss_cnt | output | CNT_W | Saturating write-miss count |
| stall_cnt | output | STALL_W | Saturating busy-cycle count |

## Verification
A wrong tag, valid or dirty flag does not show at the ports when it goes wrong. It shows on the next access to that index. A wrong flag there turns an expected hit into a miss, which moves a counter and adds busy cycles in that same request. A lost or spurious dirty flag changes the set of write-backs issued on the next replacement of that line. The bench therefore compares every memory transaction, at its done cycle, against a behavioural model of the line state. It compares the stall counter with the observed busy cycles on every clock, and the hit/miss counters after each request.

// File: rtl/wbc_pkg.sv
// Package: shared encodings for the word-dirty cache controller.
// Assumes: the CPU type field is two bits wide.
package wbc_pkg;

    // CPU access type codes as seen on cpu_type
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_t;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_WRITE = 2'd3
    } st_t;

    // Slots of the access counter bank
    localparam int CNT_RD_HIT  = 0;
    localparam int CNT_RD_MISS = 1;
    localparam int CNT_WR_HIT  = 2;
    localparam int CNT_WR_MISS = 3;
    localparam int NUM_ACC_CNT = 4;

endpackage

// File: rtl/wbc_addr_split.sv
// Module: wbc_addr_split
// Cuts a word address into tag, line index and word offset by bit slicing.
// Assumes: ADDR_W > OFF_W + IDX_W, and OFF_W and IDX_W are both at least 1.
module wbc_addr_split #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off
);

    // Fixed field slicing: offset lowest, then index, tag on top
    always_comb begin
        off = addr[OFF_W-1:0];
        idx = addr[OFF_W+IDX_W-1:OFF_W];
        tag = addr[ADDR_W-1:OFF_W+IDX_W];
    end

endmodule

// File: rtl/wbc_line_store.sv
// Module: wbc_line_store
// Holds valid flag, tag and per-word dirty flags for every line of a
// direct-mapped cache. One combinational lookup port; refill and
// dirty-mark updates happen on the clock edge.
// Assumes: refill and dirty-mark never target the same line in one cycle.
module wbc_line_store #(
    parameter int NUM_LINES = 16,
    parameter int WPL       = 4,
    parameter int TAG_W     = 10,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int OFF_W    = $clog2(WPL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [TAG_W-1:0] lk_tag,
    output logic [WPL-1:0]   lk_dirty,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic [OFF_W-1:0] mark_word
);

    logic             valid_q [NUM_LINES];
    logic [TAG_W-1:0] tag_q   [NUM_LINES];
    logic [WPL-1:0]   dirty_q [NUM_LINES];

    // Per-line state: cleared on reset, loaded on refill, dirty bit set on mark
    for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[gl] <= 1'b0;
                tag_q[gl]   <= '0;
                dirty_q[gl] <= '0;
            end else if (fill_en && (fill_idx == IDX_W'(gl))) begin
                valid_q[gl] <= 1'b1;
                tag_q[gl]   <= fill_tag;
                dirty_q[gl] <= '0;
            end else if (mark_en && (mark_idx == IDX_W'(gl))) begin
                dirty_q[gl][mark_word] <= 1'b1;
            end
        end
    end

    // Lookup port: select the addressed line
    always_comb begin
        lk_valid = valid_q[lk_idx];
        lk_tag   = tag_q[lk_idx];
        lk_dirty = dirty_q[lk_idx];
    end

endmodule

// File: rtl/wbc_sat_counter.sv
// Module: wbc_sat_counter
// Event counter that stops at its all-ones value instead of wrapping.
// Assumes: at most one event per cycle.
module wbc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Count up while below the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && (cnt != {W{1'b1}}))
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wbc_cache_ctl.sv
// Module: wbc_cache_ctl (top)
// Direct-mapped cache controller with per-word dirty tracking and no data
// payload. Reads allocate; writes hit in place (write-back or write-through
// by parameter) and miss around the cache. Replacement writes back only the
// dirty words of the victim, then refills the whole line word by word.
// Assumes: requests are presented only while cpu_busy is low; memory answers
// every mem_req with one mem_done pulse; WORDS_PER_LINE and NUM_LINES are
// powers of two, each at least 2.
module wbc_cache_ctl #(
    parameter int ADDR_W         = 16,
    parameter int WORDS_PER_LINE = 4,
    parameter int NUM_LINES      = 16,
    parameter bit WRITE_BACK     = 1'b1,
    parameter int CNT_W          = 16,
    parameter int STALL_W        = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_type,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done,
    output logic [CNT_W-1:0]  rd_hit_cnt,
    output logic [CNT_W-1:0]  rd_miss_cnt,
    output logic [CNT_W-1:0]  wr_hit_cnt,
    output logic [CNT_W-1:0]  wr_miss_cnt,
    output logic [STALL_W-1:0] stall_cnt
);
    import wbc_pkg::*;

    localparam int OFF_W = $clog2(WORDS_PER_LINE);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS_PER_LINE - 1);

    st_t               st_q, st_n;
    logic [ADDR_W-1:0] req_q;
    logic [OFF_W-1:0]  ptr_q, ptr_n;

    logic [TAG_W-1:0]  c_tag, q_tag;
    logic [IDX_W-1:0]  c_idx, q_idx;
    logic [OFF_W-1:0]  c_off, q_off;

    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [WORDS_PER_LINE-1:0] lk_dirty;
    logic [IDX_W-1:0]  lk_idx;

    logic              fill_en, mark_en;
    logic              accept, is_read, is_write, hit, evict_need;
    logic [NUM_ACC_CNT-1:0] acc_inc;
    logic [CNT_W-1:0]  acc_cnt [NUM_ACC_CNT];

    // Field split of the incoming and the latched request addresses
    wbc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_cpu (
        .addr (cpu_addr), .tag (c_tag), .idx (c_idx), .off (c_off)
    );
    wbc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_req (
        .addr (req_q), .tag (q_tag), .idx (q_idx), .off (q_off)
    );

    // Lookup uses the live address when idle, the latched one while busy
    assign lk_idx = (st_q == ST_IDLE) ? c_idx : q_idx;

    wbc_line_store #(
        .NUM_LINES (NUM_LINES), .WPL (WORDS_PER_LINE), .TAG_W (TAG_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_dirty  (lk_dirty),
        .fill_en   (fill_en),
        .fill_idx  (q_idx),
        .fill_tag  (q_tag),
        .mark_en   (mark_en),
        .mark_idx  (c_idx),
        .mark_word (c_off)
    );

    // Request decode and hit detection
    always_comb begin
        accept     = cpu_req && (st_q == ST_IDLE);
        is_read    = (acc_t'(cpu_type) == ACC_FETCH) || (acc_t'(cpu_type) == ACC_LOAD);
        is_write   = (acc_t'(cpu_type) == ACC_STORE);
        hit        = lk_valid && (lk_tag == c_tag);
        evict_need = lk_valid && lk_dirty[ptr_q];
    end

    // Next-state, counter events and line-store updates
    always_comb begin
        st_n    = st_q;
        ptr_n   = ptr_q;
        acc_inc = '0;
        fill_en = 1'b0;
        mark_en = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (accept && is_read) begin
                    if (hit) begin
                        acc_inc[CNT_RD_HIT] = 1'b1;
                    end else begin
                        acc_inc[CNT_RD_MISS] = 1'b1;
                        st_n  = ST_EVICT;
                        ptr_n = '0;
                    end
                end else if (accept && is_write) begin
                    if (hit) begin
                        acc_inc[CNT_WR_HIT] = 1'b1;
                        if (WRITE_BACK) mark_en = 1'b1;
                        else            st_n    = ST_WRITE;
                    end else begin
                        acc_inc[CNT_WR_MISS] = 1'b1;
                        st_n = ST_WRITE;
                    end
                end
            end
            ST_EVICT: begin
                if (!evict_need || mem_done) begin
                    if (ptr_q == LAST_WORD) begin
                        st_n  = ST_FILL;
                        ptr_n = '0;
                    end else begin
                        ptr_n = ptr_q + 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_done) begin
                    if (ptr_q == LAST_WORD) begin
                        fill_en = 1'b1;
                        st_n    = ST_IDLE;
                        ptr_n   = '0;
                    end else begin
                        ptr_n = ptr_q + 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_done) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Sequencer registers and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
            req_q <= '0;
        end else begin
            st_q  <= st_n;
            ptr_q <= ptr_n;
            if (accept) req_q <= cpu_addr;
        end
    end

    // Memory port drive per state
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        case (st_q)
            ST_EVICT: begin
                mem_req  = evict_need;
                mem_we   = evict_need;
                mem_addr = {lk_tag, q_idx, ptr_q};
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {q_tag, q_idx, ptr_q};
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {q_tag, q_idx, q_off};
            end
            default: ;
        endcase
    end

    assign cpu_busy = (st_q != ST_IDLE);

    // Access counter bank
    for (genvar gc = 0; gc < NUM_ACC_CNT; gc++) begin : g_acc
        wbc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk (clk), .rst_n (rst_n), .inc (acc_inc[gc]), .cnt (acc_cnt[gc])
        );
    end

    wbc_sat_counter #(.W(STALL_W)) u_stall (
        .clk (clk), .rst_n (rst_n), .inc (cpu_busy), .cnt (stall_cnt)
    );

    assign rd_hit_cnt  = acc_cnt[CNT_RD_HIT];
    assign rd_miss_cnt = acc_cnt[CNT_RD_MISS];
    assign wr_hit_cnt  = acc_cnt[CNT_WR_HIT];
    assign wr_miss_cnt = acc_cnt[CNT_WR_MISS];

endmodule

// File: rtl/wbc_checker.sv
// Module: wbc_checker
// Port-level temporal checks for wbc_cache_ctl, attached by bind below.
// Assumes: the same parameter values as the bound controller instance.
module wbc_checker #(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int STALL_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [1:0]        cpu_type,
    input logic              cpu_busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_done,
    input logic [CNT_W-1:0]  rd_hit_cnt,
    input logic [CNT_W-1:0]  rd_miss_cnt,
    input logic [CNT_W-1:0]  wr_hit_cnt,
    input logic [CNT_W-1:0]  wr_miss_cnt,
    input logic [STALL_W-1:0] stall_cnt
);

    AST_TYPE3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && cpu_type == 2'd3) |=> (!cpu_busy && !mem_req)); // R2

    AST_COUNT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && !cpu_busy) |=> ($stable(rd_hit_cnt) && $stable(rd_miss_cnt)
                                     && $stable(wr_hit_cnt) && $stable(wr_miss_cnt))); // R3

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4

    AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_busy); // R9

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_busy && stall_cnt != {STALL_W{1'b1}})
            |=> (stall_cnt == STALL_W'($past(stall_cnt) + 1'b1))); // R9

    AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_busy |=> $stable(stall_cnt)); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_cnt == {CNT_W{1'b1}}) |=> (rd_hit_cnt == {CNT_W{1'b1}})); // R10

endmodule

bind wbc_cache_ctl wbc_checker #(
    .ADDR_W (ADDR_W), .CNT_W (CNT_W), .STALL_W (STALL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_type    (cpu_type),
    .cpu_busy    (cpu_busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_done    (mem_done),
    .rd_hit_cnt  (rd_hit_cnt),
    .rd_miss_cnt (rd_miss_cnt),
    .wr_hit_cnt  (wr_hit_cnt),
    .wr_miss_cnt (wr_miss_cnt),
    .stall_cnt   (stall_cnt)
);

// File: tb/tb_wbc_cache_ctl.sv
// Bench: drives a write-back instance (index 0) and a write-through
// instance (index 1) against a behavioural model of line state, memory
// traffic, busy time and counters.
module tb_wbc_cache_ctl;

    localparam int AW  = 12;
    localparam int WPL = 4;
    localparam int NL  = 4;
    localparam int OFF = 2;
    localparam int IDX = 2;
    localparam int LAT = 2;
    localparam int CW  = 4;
    localparam int SW  = 12;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [1:0]    cpu_req;
    logic [1:0]    cpu_type [2];
    logic [AW-1:0] cpu_addr [2];
    logic [1:0]    cpu_busy;
    logic [1:0]    mem_req, mem_we, mem_done;
    logic [AW-1:0] mem_addr [2];
    logic [CW-1:0] cnt_o [2][4];
    logic [SW-1:0] stall_o [2];

    wbc_cache_ctl #(.ADDR_W(AW), .WORDS_PER_LINE(WPL), .NUM_LINES(NL),
                    .WRITE_BACK(1'b1), .CNT_W(CW), .STALL_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_type(cpu_type[0]),
        .cpu_addr(cpu_addr[0]), .cpu_busy(cpu_busy[0]), .mem_req(mem_req[0]),
        .mem_we(mem_we[0]), .mem_addr(mem_addr[0]), .mem_done(mem_done[0]),
        .rd_hit_cnt(cnt_o[0][0]), .rd_miss_cnt(cnt_o[0][1]),
        .wr_hit_cnt(cnt_o[0][2]), .wr_miss_cnt(cnt_o[0][3]), .stall_cnt(stall_o[0]));

    wbc_cache_ctl #(.ADDR_W(AW), .WORDS_PER_LINE(WPL), .NUM_LINES(NL),
                    .WRITE_BACK(1'b0), .CNT_W(CW), .STALL_W(SW)) dut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_type(cpu_type[1]),
        .cpu_addr(cpu_addr[1]), .cpu_busy(cpu_busy[1]), .mem_req(mem_req[1]),
        .mem_we(mem_we[1]), .mem_addr(mem_addr[1]), .mem_done(mem_done[1]),
        .rd_hit_cnt(cnt_o[1][0]), .rd_miss_cnt(cnt_o[1][1]),
        .wr_hit_cnt(cnt_o[1][2]), .wr_miss_cnt(cnt_o[1][3]), .stall_cnt(stall_o[1]));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Model state
    int mv [2][NL];
    int mt [2][NL];
    int md [2][NL][WPL];
    int mc [2][4];
    int sm [2];
    logic [AW:0] q0 [$];
    logic [AW:0] q1 [$];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int t, input int i, input int w);
        return AW'((t << (OFF + IDX)) | (i << OFF) | w);
    endfunction

    task automatic push(input int m, input logic [AW:0] v);
        if (m == 0) q0.push_back(v); else q1.push_back(v);
    endtask

    function automatic int qsize(input int m);
        return (m == 0) ? q0.size() : q1.size();
    endfunction

    function automatic logic [AW:0] popq(input int m);
        if (m == 0) return q0.pop_front();
        return q1.pop_front();
    endfunction

    task automatic bump(input int m, input int k);
        if (mc[m][k] < CMAX) mc[m][k]++;
    endtask

    // Memory responder: done pulse LAT cycles after a request starts
    int lat_cnt [2];
    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                lat_cnt[m]  <= 0;
                mem_done[m] <= 1'b0;
            end else if (mem_done[m]) begin
                lat_cnt[m]  <= 0;
                mem_done[m] <= 1'b0;
            end else if (mem_req[m]) begin
                if (lat_cnt[m] == LAT - 1) mem_done[m] <= 1'b1;
                else lat_cnt[m] <= lat_cnt[m] + 1;
            end
        end
    end

    // Per-clock comparison: memory transactions and stall counter
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < 2; m++) begin
                if (mem_done[m]) begin
                    if (qsize(m) == 0) begin
                        chk(1'b0, "R7", "unexpected memory access", int'({mem_we[m], mem_addr[m]}), -1);
                    end else begin
                        logic [AW:0] e;
                        e = popq(m);
                        chk({mem_we[m], mem_addr[m]} == e, "R7", "memory {we,addr}",
                            int'({mem_we[m], mem_addr[m]}), int'(e));
                    end
                end
                chk(int'(stall_o[m]) == sm[m], "R9", "stall counter", int'(stall_o[m]), sm[m]);
                if (cpu_busy[m] && sm[m] < (1 << SW) - 1) sm[m]++;
            end
        end else begin
            sm[0] = 0;
            sm[1] = 0;
        end
    end

    // One CPU access with model prediction and post-checks
    task automatic do_req(input int m, input int ty, input int t, input int i,
                          input int w, input string rq);
        int eb;
        int n;
        logic [AW-1:0] a;
        a  = mk(t, i, w);
        eb = 0;
        if (ty == 0 || ty == 1) begin
            if (mv[m][i] != 0 && mt[m][i] == t) begin
                bump(m, 0);
            end else begin
                bump(m, 1);
                for (int ww = 0; ww < WPL; ww++) begin
                    if (mv[m][i] != 0 && md[m][i][ww] != 0) begin
                        push(m, {1'b1, mk(mt[m][i], i, ww)});
                        eb += LAT + 1;
                    end else begin
                        eb += 1;
                    end
                end
                for (int ww = 0; ww < WPL; ww++) begin
                    push(m, {1'b0, mk(t, i, ww)});
                    eb += LAT + 1;
                end
                mv[m][i] = 1;
                mt[m][i] = t;
                for (int ww = 0; ww < WPL; ww++) md[m][i][ww] = 0;
            end
        end else if (ty == 2) begin
            if (mv[m][i] != 0 && mt[m][i] == t) begin
                bump(m, 2);
                if (m == 0) begin
                    md[m][i][w] = 1;
                end else begin
                    push(m, {1'b1, a});
                    eb = LAT + 1;
                end
            end else begin
                bump(m, 3);
                push(m, {1'b1, a});
                eb = LAT + 1;
            end
        end
        cpu_req[m]  = 1'b1;
        cpu_type[m] = 2'(ty);
        cpu_addr[m] = a;
        @(negedge clk);
        cpu_req[m] = 1'b0;
        n = 0;
        while (cpu_busy[m] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == eb, rq, "R9 busy cycles", n, eb);
        chk(qsize(m) == 0, rq, "R7 pending memory accesses", qsize(m), 0);
        chk(int'(cnt_o[m][0]) == mc[m][0], rq, "R3 read-hit count", int'(cnt_o[m][0]), mc[m][0]);
        chk(int'(cnt_o[m][1]) == mc[m][1], rq, "R4 read-miss count", int'(cnt_o[m][1]), mc[m][1]);
        chk(int'(cnt_o[m][2]) == mc[m][2], rq, "R5/R6 write-hit count", int'(cnt_o[m][2]), mc[m][2]);
        chk(int'(cnt_o[m][3]) == mc[m][3], rq, "R8 write-miss count", int'(cnt_o[m][3]), mc[m][3]);
    endtask

    task automatic run_suite(input int m);
        string whit;
        whit = (m == 0) ? "R6" : "R5";
        do_req(m, 1, 1, 1, 2, "R4");     // cold read miss, line refill
        do_req(m, 1, 1, 1, 0, "R3");     // same line, other word: hit
        do_req(m, 0, 1, 1, 3, "R2");     // fetch treated as read: hit
        do_req(m, 2, 1, 1, 1, whit);     // write hit word 1
        do_req(m, 2, 1, 1, 3, whit);     // write hit word 3
        do_req(m, 2, 3, 1, 0, "R8");     // write miss goes around
        do_req(m, 1, 1, 1, 1, "R8");     // cached line untouched: hit
        do_req(m, 3, 1, 1, 1, "R2");     // type 3 ignored
        do_req(m, 1, 2, 1, 0, "R7");     // conflict: dirty words 1,3 only (WB)
        do_req(m, 1, 3, 1, 2, "R8");     // write-miss address was not allocated
        do_req(m, 1, 1, 2, 0, "R1");     // other index miss
        do_req(m, 1, 3, 1, 0, "R1");     // index 1 unaffected: hit
        do_req(m, 2, 3, 1, 2, whit);     // dirty word 2
        do_req(m, 1, 4, 1, 0, "R7");     // evict word 2 only
        do_req(m, 1, 3, 1, 0, "R4");     // refilled line came back clean
        do_req(m, 2, 3, 1, 0, whit);
        do_req(m, 2, 3, 1, 3, whit);
        do_req(m, 1, 5, 1, 0, "R7");     // words 0 and 3 written back
        for (int k = 0; k < 20; k++) do_req(m, 1, 5, 1, k % WPL, "R10");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            cpu_req[m] = 1'b0; cpu_type[m] = 2'd0; cpu_addr[m] = '0;
            sm[m] = 0;
            for (int k = 0; k < 4; k++) mc[m][k] = 0;
            for (int i = 0; i < NL; i++) begin
                mv[m][i] = 0; mt[m][i] = 0;
                for (int w = 0; w < WPL; w++) md[m][i][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk(cpu_busy[m] == 1'b0, "R11", "busy after reset", int'(cpu_busy[m]), 0);
            chk(mem_req[m] == 1'b0, "R11", "mem_req after reset", int'(mem_req[m]), 0);
            for (int k = 0; k < 4; k++)
                chk(cnt_o[m][k] == '0, "R11", "counter after reset", int'(cnt_o[m][k]), 0);
            chk(stall_o[m] == '0, "R11", "stall after reset", int'(stall_o[m]), 0);
        end
        run_suite(0);
        run_suite(1);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual %0d cycles expected fewer", 100000);
        finish_run();
    end

endmodule